// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes one input clock and drives one output clock at the input frequency divided by a power of two, from /2 up to /128, or passes the input clock through unchanged. A three-bit select word picks the ratio. The code runs downward in ratio: all-zeros gives the deepest division, and all-ones bypasses the divider.

Internally a seven-bit synchronous counter, clocked only by the input clock, forms the halving chain. Counter bit k is a square wave at the input frequency over 2^(k+1). An output multiplexer routes one counter bit, or the raw clock, to the output. A change of the select word reaches the output at once. No resynchronisation is done, so a switch between ratios may glitch.

Top module: `pow2_clk_div`

## Requirements
- R1: The chain is a seven-bit counter that advances by one on every rising input edge. Stage k changes level exactly on the edges where all lower stages were high before the edge, and holds otherwise. Stage 0 changes on every edge.
- R2: The select word is `sel_i[2:0]`, with `sel_i[2]` as the most significant bit. Code 0 gives /128, 1 gives /64, 2 gives /32, 3 gives /16, 4 gives /8, 5 gives /4 and 6 gives /2. Code c (c < 7) routes counter bit 6-c to `div_clk_o`.
- R3: Code 7 routes `clk_i` itself to `div_clk_o`, so the output has the input's frequency and phase.
- R4: `rst_i` is active high and synchronous. It clears every stage to zero on a rising clock edge. While reset is held, and on the first cycle after it is released, every divided output is low.
- R5: For ratio N the divided output has a 50% duty cycle: N/2 input cycles high, then N/2 input cycles low.
- R6: A change of `sel_i` reaches `div_clk_o` combinationally, in the same cycle, with no extra delay and no change to the counter.
- R7: After reset is released, the divided output for ratio N first goes high on the (N/2)-th rising input edge. Over any 256-cycle window that starts at reset release it produces exactly 256/N rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset of the divider chain |
| sel_i | input | 3 | Ratio select code; all-zeros is /128, all-ones is bypass |
| div_clk_o | output | 1 | Divided (or bypassed) output clock |

## Verification
The bench targets three kinds of fault. The first is a reversed or off-by-one code-to-stage mapping; this shows up as a rising-edge count that is twice or half the expected 256/N. The second is a bypass path that does not follow the input clock; the output then stays low during the high phase. The third is a reset that leaves a stage set; the output then rises early, before the (N/2)-th edge, and the duty count moves off 128 high samples. The bench also sweeps the select word on every cycle without a reset, so a multiplexer that registered or delayed the select would show the old ratio's level one cycle late.

// File: rtl/pow2_clk_div_pkg.sv
package pow2_clk_div_pkg;

  // Number of halving stages in the chain.
  localparam int unsigned STAGES_DEF = 7;

  // Width of a select word able to name every stage plus the bypass.
  function automatic int unsigned sel_width(input int unsigned stages);
    return $clog2(stages + 1);
  endfunction

  // Stage index addressed by a select code (code 0 is the deepest stage).
  function automatic int unsigned code_to_stage(input int unsigned code,
                                                input int unsigned stages);
    return stages - 1 - code;
  endfunction

endpackage

// File: rtl/pow2_stage_chain.sv
module pow2_stage_chain #(
  parameter int unsigned STAGES = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic [STAGES-1:0] stage_o
);

  logic [STAGES-1:0] cnt_q;

  // A single synchronous counter: bit k toggles when bits below it are all ones.
  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign stage_o = cnt_q;

endmodule

// File: rtl/pow2_tap_mux.sv
module pow2_tap_mux
  import pow2_clk_div_pkg::*;
#(
  parameter int unsigned STAGES = 7,
  localparam int unsigned SEL_W = sel_width(STAGES),
  localparam int unsigned CODES = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic [STAGES-1:0] stage_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tap_o
);

  logic [CODES-1:0] taps;

  // Codes below STAGES select a stage (deepest first); the rest bypass.
  for (genvar c = 0; c < CODES; c++) begin : g_tap
    if (c < STAGES) begin : g_stage
      assign taps[c] = stage_i[code_to_stage(c, STAGES)];
    end else begin : g_bypass
      assign taps[c] = clk_i;
    end
  end

  always_comb begin
    tap_o = taps[sel_i];
  end

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_clk_div_pkg::*;
#(
  parameter int unsigned STAGES = STAGES_DEF,
  localparam int unsigned SEL_W = sel_width(STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_clk_o
);

  logic [STAGES-1:0] stage_q;

  pow2_stage_chain #(.STAGES(STAGES)) chain_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .stage_o (stage_q)
  );

  pow2_tap_mux #(.STAGES(STAGES)) mux_i (
    .clk_i   (clk_i),
    .stage_i (stage_q),
    .sel_i   (sel_i),
    .tap_o   (div_clk_o)
  );

endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk #(
  parameter int unsigned STAGES = 7,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [STAGES-1:0] stage_q,
  input logic              div_clk_o
);

  // R1: stage 0 flips on every edge out of reset.
  p_bit0_toggle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (rst_i || stage_q[0] != $past(stage_q[0])));

  for (genvar k = 1; k < STAGES; k++) begin : g_stage_chk
    // R1: stage k flips only when all lower stages are high.
    p_stage_toggle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (&stage_q[k-1:0]) |=> (rst_i || stage_q[k] != $past(stage_q[k])));
    p_stage_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      !(&stage_q[k-1:0]) |=> (rst_i || $stable(stage_q[k])));
  end

  // R4: first cycle after reset release, divided outputs are low.
  p_low_after_reset_r4: assert property (@(posedge clk_i)
    ($fell(rst_i) && sel_i != {SEL_W{1'b1}}) |-> !div_clk_o);

  // R3: bypass output follows the input clock.
  p_bypass_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == {SEL_W{1'b1}}) |-> (div_clk_o == clk_i));

endmodule

bind pow2_clk_div pow2_clk_div_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .sel_i     (sel_i),
  .stage_q   (stage_q),
  .div_clk_o (div_clk_o)
);

// File: tb/pow2_clk_div_tb_top.sv
`timescale 1ns/1ps
module pow2_clk_div_tb_top;

  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       div_clk;

  int tests = 0;
  int fails = 0;
  int edges = 0;
  int model_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pow2_clk_div dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .sel_i     (sel),
    .div_clk_o (div_clk)
  );

  always @(posedge div_clk) edges++;

  function automatic int ratio(input int code);
    return (code == 7) ? 1 : (128 >> code);
  endfunction

  // Expected level in the low clock phase, from R2/R3: code c shows counter bit 6-c.
  function automatic logic exp_low(input int code, input int cnt);
    if (code == 7) return 1'b0;
    return 1'((cnt >> (6 - code)) & 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_code(input int code);
    int n = ratio(code);
    int mism = 0, highs = 0, first_hi = -1, byp_bad = 0;
    @(negedge clk);
    rst = 1'b1;
    sel = 3'(code);
    repeat (3) @(negedge clk);
    if (code != 7) check("R4 output low in reset", int'(div_clk), 0);
    rst = 1'b0;
    model_cnt = 0;
    edges = 0;
    for (int i = 1; i <= WIN; i++) begin
      @(posedge clk);
      model_cnt++;
      #1;
      if (code == 7 && div_clk !== 1'b1) byp_bad++;
      @(negedge clk);
      #0.2;
      // R1/R2 stage chain and mapping compared against the behavioural count
      if (div_clk !== exp_low(code, model_cnt)) mism++;
      if (div_clk === 1'b1) begin
        highs++;
        if (first_hi < 0) first_hi = i;
      end
    end
    check($sformatf("R1 R2 per-cycle level code %0d", code), mism, 0);
    check($sformatf("R7 edge count code %0d", code), edges, WIN / n);
    if (code == 7) begin
      check("R3 bypass high phase", byp_bad, 0);
    end else begin
      check($sformatf("R5 duty code %0d", code), highs, WIN / 2);
      check($sformatf("R7 first rise code %0d", code), first_hi, n / 2);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int c = 0; c < 8; c++) run_code(c);
    // R6: select changes every cycle without reset, output follows at once.
    begin
      int mism = 0;
      for (int i = 0; i < 200; i++) begin
        @(posedge clk);
        model_cnt++;
        @(negedge clk);
        sel = 3'((i * 3 + i / 8) % 8);
        #0.2;
        if (div_clk !== exp_low(int'(sel), model_cnt)) mism++;
      end
      check("R6 immediate select change", mism, 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule